// File: doc/BRIEF.md
# Priority counter pair

Two counters, x and y, are shared by a small set of update processes. Each process has its own request input, and in every clock cycle the block decides which requested processes commit. A counter accepts at most one update per cycle. When two requested processes would touch the same counter, the one earlier in a fixed urgency order wins. A process that loses is held back only by a conflicting process that really commits in that cycle. A request alone does not hold anything back, so several processes that do not conflict can commit together.

The base configuration has three processes. Process 0 adds one to x. Process 1 moves one unit from x to y. Process 2 takes one from y. Urgency runs 2, then 1, then 0. A compile-time switch selects an extended configuration with a fourth process, which adds two to x and takes two from y. In that configuration process 2 also adds one to x, and urgency runs 2, 3, 1, 0. Both counters saturate at zero and at their maximum instead of wrapping. The fired vector reports which processes commit in the current cycle. Requests, fired bits and counters are plain control and status pins; the block has no streaming interface.

Top module: `prio_counter_pair`

## Requirements
- R1: Reset is synchronous and active low. While rst_n is low, fired is all zero, and x and y are zero after the next rising edge.
- R2: With only req[0] asserted, fired is 'b001 and x rises by one at the next edge while y holds.
- R3: With only req[1] asserted, x falls by one and y rises by one at the same edge.
- R4: In the base configuration, with only req[2] asserted, y falls by one and x holds.
- R5: In the base configuration, urgency is process 2, then 1, then 0, and no counter takes more than one update per cycle. Requests 'b110 (bit i = process i) fire only process 2.
- R6: A lower-urgency process is blocked only by a conflicting process that fires. Requests 'b111 fire 'b101, so x rises by one and y falls by one. Requests 'b011 fire 'b010.
- R7: Bit i of fired is high exactly when process i commits in the current cycle. It follows req in the same cycle, and it is never high for a process that is not requested.
- R8: A counter at its maximum (2^CNT_W-1) stays there when an update would push it higher.
- R9: A counter at zero stays at zero when an update would push it lower. The other counter's half of a move still applies.
- R10: With EXT_ORDER=1 there are four processes. Process 3 adds two to x and takes two from y. Process 2 adds one to x and takes one from y. Urgency is 2, 3, 1, 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | NPROC | Per-process request, bit i for process i |
| fired | output | NPROC | Per-process commit indication for the current cycle |
| x | output | CNT_W | First shared counter |
| y | output | CNT_W | Second shared counter |

## Verification
The interesting coincidence is the x increment of process 0 and the y decrement of process 2 landing in one cycle, while process 1 is requested and loses to process 2. The bench provokes it by raising all three requests together. It judges the result by fired reading 'b101 and both counters moving at the next edge. A sweep of every request combination, in both configurations, compares fired and the counters against an urgency-ordered model. Saturation at both ends is provoked with long runs of a single request.

// File: rtl/pcp_pkg.sv
package pcp_pkg;
  localparam int DELTA_W = 3;
  typedef logic signed [DELTA_W-1:0] delta_t;

  // Process index held at urgency rank r (rank 0 is most urgent).
  function automatic int urgency_slot(input int r, input bit ext);
    if (ext) begin
      case (r)
        0: return 2;
        1: return 3;
        2: return 1;
        default: return 0;
      endcase
    end
    case (r)
      0: return 2;
      1: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic delta_t x_step(input int p, input bit ext);
    case (p)
      0: return delta_t'(1);
      1: return delta_t'(-1);
      2: return ext ? delta_t'(1) : delta_t'(0);
      3: return delta_t'(2);
      default: return delta_t'(0);
    endcase
  endfunction

  function automatic delta_t y_step(input int p, input bit ext);
    case (p)
      1: return delta_t'(1);
      2: return delta_t'(-1);
      3: return ext ? delta_t'(-2) : delta_t'(0);
      default: return delta_t'(0);
    endcase
  endfunction

  // Bit 0: touches x, bit 1: touches y.
  function automatic logic [1:0] footprint(input int p, input bit ext);
    return {y_step(p, ext) != '0, x_step(p, ext) != '0};
  endfunction
endpackage

// File: rtl/pcp_sched.sv
module pcp_sched
  import pcp_pkg::*;
#(
  parameter bit EXT   = 1'b0,
  parameter int NPROC = 3
) (
  input  logic [NPROC-1:0] req,
  output logic [NPROC-1:0] grant
);
  logic [1:0] busy;

  // Walk ranks from most urgent; a request commits if no committed
  // process already holds one of the counters it writes.
  always_comb begin
    busy  = 2'b00;
    grant = '0;
    for (int r = 0; r < NPROC; r++) begin
      if (req[urgency_slot(r, EXT)] &&
          ((footprint(urgency_slot(r, EXT), EXT) & busy) == 2'b00)) begin
        grant[urgency_slot(r, EXT)] = 1'b1;
        busy = busy | footprint(urgency_slot(r, EXT), EXT);
      end
    end
  end
endmodule

// File: rtl/pcp_delta.sv
module pcp_delta
  import pcp_pkg::*;
#(
  parameter bit EXT   = 1'b0,
  parameter int NPROC = 3
) (
  input  logic [NPROC-1:0]   fired,
  output pcp_pkg::delta_t [1:0] step
);
  // At most one committed process writes each counter, so the
  // selected step is simply the one from that process.
  always_comb begin
    step = '0;
    for (int p = 0; p < NPROC; p++) begin
      if (fired[p]) begin
        if (x_step(p, EXT) != '0) step[0] = x_step(p, EXT);
        if (y_step(p, EXT) != '0) step[1] = y_step(p, EXT);
      end
    end
  end
endmodule

// File: rtl/pcp_sat_reg.sv
module pcp_sat_reg
  import pcp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  delta_t       step,
  output logic [W-1:0] q
);
  localparam int SW = W + DELTA_W;
  localparam logic signed [SW-1:0] CEIL = {{DELTA_W{1'b0}}, {W{1'b1}}};

  logic signed [SW-1:0] sum;
  logic [W-1:0]         nxt;

  always_comb begin
    sum = $signed({{DELTA_W{1'b0}}, q}) + $signed({{W{step[DELTA_W-1]}}, step});
    if (sum[SW-1])      nxt = '0;
    else if (sum > CEIL) nxt = {W{1'b1}};
    else                 nxt = sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/prio_counter_pair.sv
module prio_counter_pair
  import pcp_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter bit EXT_ORDER = 1'b0,
  parameter int NPROC     = EXT_ORDER ? 4 : 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPROC-1:0] req,
  output logic [NPROC-1:0] fired,
  output logic [CNT_W-1:0] x,
  output logic [CNT_W-1:0] y
);
  localparam int NREG = 2;

  logic [NPROC-1:0]    grant;
  delta_t [NREG-1:0]   step;
  logic [CNT_W-1:0]    cnt [NREG];

  pcp_sched #(.EXT(EXT_ORDER), .NPROC(NPROC)) u_sched (
    .req   (req),
    .grant (grant)
  );

  assign fired = rst_n ? grant : '0;

  pcp_delta #(.EXT(EXT_ORDER), .NPROC(NPROC)) u_delta (
    .fired (fired),
    .step  (step)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_cnt
    pcp_sat_reg #(.W(CNT_W)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step[i]),
      .q     (cnt[i])
    );
  end

  assign x = cnt[0];
  assign y = cnt[1];
endmodule

// File: rtl/pcp_chk.sv
module pcp_chk
  import pcp_pkg::*;
#(
  parameter int W     = 16,
  parameter bit EXT   = 1'b0,
  parameter int NPROC = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPROC-1:0] req,
  input logic [NPROC-1:0] fired,
  input logic [W-1:0]     x,
  input logic [W-1:0]     y
);
  logic [NPROC-1:0] x_users, y_users, x_down, y_up;

  always_comb begin
    for (int p = 0; p < NPROC; p++) begin
      x_users[p] = fired[p] && footprint(p, EXT)[0];
      y_users[p] = fired[p] && footprint(p, EXT)[1];
      x_down[p]  = fired[p] && (x_step(p, EXT) < 0);
      y_up[p]    = fired[p] && (y_step(p, EXT) > 0);
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (x == '0 && y == '0));

  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    !rst_n |-> fired == '0);

  assert_fire_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fired & ~req) == '0);

  assert_one_writer_x_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(x_users) <= 1);

  assert_one_writer_y_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(y_users) <= 1);

  assert_most_urgent_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req[2] |-> fired[2]);

  assert_x_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (x_users == '0) |=> $stable(x));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (x == {W{1'b1}} && x_down == '0) |=> (x == {W{1'b1}}));

  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (y == '0 && y_up == '0) |=> (y == '0));
endmodule

bind prio_counter_pair pcp_chk #(.W(CNT_W), .EXT(EXT_ORDER), .NPROC(NPROC)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .req   (req),
  .fired (fired),
  .x     (x),
  .y     (y)
);

// File: tb/sim_prio_counter_pair.sv
`timescale 1ns/1ps
module sim_prio_counter_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  req0 = '0;
  logic [3:0]  req1 = '0;
  logic [2:0]  fired0;
  logic [3:0]  fired1;
  logic [15:0] x0, y0;
  logic [7:0]  x1, y1;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int ex0 = 0, ey0 = 0, ex1 = 0, ey1 = 0;

  always #2.5 clk = ~clk;

  prio_counter_pair #(.CNT_W(16), .EXT_ORDER(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req0), .fired(fired0), .x(x0), .y(y0));

  prio_counter_pair #(.CNT_W(8), .EXT_ORDER(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .req(req1), .fired(fired1), .x(x1), .y(y1));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] model_fire(input logic [3:0] r, input bit ext);
    logic [3:0] g = '0;
    g[2] = r[2];
    if (!ext) begin
      g[1] = r[1] & ~g[2];
      g[0] = r[0] & ~g[1];
    end else begin
      g[3] = r[3] & ~g[2];
      g[1] = r[1] & ~g[2] & ~g[3];
      g[0] = r[0] & ~g[2] & ~g[3] & ~g[1];
    end
    return g;
  endfunction

  function automatic int dx_of(input logic [3:0] g, input bit ext);
    return (g[0] ? 1 : 0) - (g[1] ? 1 : 0) + ((ext && g[2]) ? 1 : 0) + (g[3] ? 2 : 0);
  endfunction

  function automatic int dy_of(input logic [3:0] g);
    return (g[1] ? 1 : 0) - (g[2] ? 1 : 0) - (g[3] ? 2 : 0);
  endfunction

  function automatic int clampv(input int v, input int maxv);
    if (v < 0) return 0;
    if (v > maxv) return maxv;
    return v;
  endfunction

  // Each step starts at a falling edge and spends exactly one rising edge.
  task automatic step_base(input logic [2:0] r, input string tag);
    logic [3:0] g;
    g = model_fire({1'b0, r}, 1'b0);
    req0 = r;
    #1;
    check(fired0 == g[2:0], {tag, " fired"}, int'(fired0), int'(g[2:0]));
    ex0 = clampv(ex0 + dx_of(g, 1'b0), 65535);
    ey0 = clampv(ey0 + dy_of(g), 65535);
    @(posedge clk);
    #1 req0 = '0;
    @(negedge clk);
    check(x0 == 16'(ex0), {tag, " x"}, int'(x0), ex0);
    check(y0 == 16'(ey0), {tag, " y"}, int'(y0), ey0);
  endtask

  task automatic step_ext(input logic [3:0] r, input string tag);
    logic [3:0] g;
    g = model_fire(r, 1'b1);
    req1 = r;
    #1;
    check(fired1 == g, {tag, " fired"}, int'(fired1), int'(g));
    ex1 = clampv(ex1 + dx_of(g, 1'b1), 255);
    ey1 = clampv(ey1 + dy_of(g), 255);
    @(posedge clk);
    #1 req1 = '0;
    @(negedge clk);
    check(x1 == 8'(ex1), {tag, " x"}, int'(x1), ex1);
    check(y1 == 8'(ey1), {tag, " y"}, int'(y1), ey1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    req0 = 3'b111;
    req1 = 4'b1111;
    repeat (3) @(negedge clk);
    check(fired0 == 3'b000, "R1 fired0 in reset", int'(fired0), 0);
    check(fired1 == 4'b0000, "R1 fired1 in reset", int'(fired1), 0);
    check(x0 == 16'd0 && y0 == 16'd0, "R1 base counters", int'(x0) + int'(y0), 0);
    check(x1 == 8'd0 && y1 == 8'd0, "R1 ext counters", int'(x1) + int'(y1), 0);
    req0 = '0;
    req1 = '0;
    rst_n = 1'b1;
  endtask

  task automatic t_singles();
    repeat (3) step_base(3'b001, "R2 inc x");
    check(x0 == 16'd3, "R2 x after three", int'(x0), 3);
    step_base(3'b010, "R3 move");
    check(x0 == 16'd2 && y0 == 16'd1, "R3 x/y after move", int'(x0) * 100 + int'(y0), 201);
    step_base(3'b100, "R4 dec y");
    check(y0 == 16'd0 && x0 == 16'd2, "R4 y after dec", int'(x0) * 100 + int'(y0), 200);
  endtask

  task automatic t_conflicts();
    step_base(3'b010, "R3 move");
    req0 = 3'b111;
    #1;
    check(fired0 == 3'b101, "R6 all three fire", int'(fired0), 5);
    req0 = '0;
    step_base(3'b111, "R6 all three");
    check(x0 == 16'd2 && y0 == 16'd0, "R6 x/y after all three", int'(x0) * 100 + int'(y0), 200);
    step_base(3'b110, "R5 two over one");
    check(y0 == 16'd0, "R9 y held at zero", int'(y0), 0);
    step_base(3'b011, "R6 one over zero");
    check(x0 == 16'd1 && y0 == 16'd1, "R6 x/y after 011", int'(x0) * 100 + int'(y0), 101);
  endtask

  task automatic t_sweep_base();
    for (int pass = 0; pass < 2; pass++)
      for (int r = 0; r < 8; r++) step_base(3'(r), "R5 R7 sweep");
  endtask

  task automatic t_saturate_x();
    req0 = 3'b001;
    repeat (65540) @(negedge clk);
    check(x0 == 16'hFFFF, "R8 x at ceiling", int'(x0), 65535);
    req0 = '0;
    ex0 = 65535;
    step_base(3'b001, "R8 inc at ceiling");
    check(x0 == 16'hFFFF, "R8 x held", int'(x0), 65535);
  endtask

  task automatic t_extended();
    step_ext(4'b1000, "R10 proc3 alone");
    check(x1 == 8'd2 && y1 == 8'd0, "R10 R9 after proc3", int'(x1) * 1000 + int'(y1), 2000);
    step_ext(4'b1111, "R10 all four");
    check(x1 == 8'd3, "R10 proc2 adds to x", int'(x1), 3);
    step_ext(4'b1011, "R10 three over one");
    step_ext(4'b0011, "R10 one over zero");
    step_ext(4'b0101, "R10 two over zero");
    for (int i = 0; i < 300; i++) step_ext(4'b0010, "R8 R9 ext move run");
    check(x1 == 8'd0 && y1 == 8'd255, "R8 R9 ext saturation", int'(x1) * 1000 + int'(y1), 255);
    for (int r = 0; r < 16; r++) step_ext(4'(r), "R10 sweep");
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    t_reset();
    t_singles();
    t_conflicts();
    t_sweep_base();
    t_saturate_x();
    t_extended();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule